// File: doc/BRIEF.md
# Low-Frequency Watchdog with Tap-Selected Postscaler

The block is a watchdog timer that advances on ticks of a slow internal RC oscillator, delivered to it as one-cycle strobes in the system clock domain. A prescaler turns a fixed number of RC ticks into one base period, nominally 4 ms. A chain of postscaler stages then multiplies that base by a power of two, chosen by a 4-bit tap select that comes from configuration and not from a runtime register. Because every count derives from the RC tick, any retuning of the RC period scales the timeout by the same factor.

The watchdog runs when the configuration enable is set. When the configuration enable is clear, a software enable can still turn it on. While enabled, it asks the oscillator controller to keep the RC source running. The count restarts on a clear-watchdog strobe, a sleep strobe, a change of the internal frequency select, or a detected clock failure. At expiry the block emits a one-cycle reset request while the device is awake, or a one-cycle wake request while it sleeps. Either event sets a sticky timeout flag.

Top module: `rc_watchdog`

## Requirements
- R1: After rst_ni is asserted, wdt_rst_o, wdt_wake_o and timeout_o are 0.
- R2: With tap_sel_i = n, an expiry happens on exactly the BASE_TICKS*2^n-th rc_tick_i strobe after the last restart, and never earlier.
- R3: An expiry while awake gives wdt_rst_o high for exactly one cycle, in the cycle after the expiring tick, and wdt_wake_o stays 0.
- R4: A sleep_i strobe marks the device asleep. An expiry while asleep gives wdt_wake_o high for one cycle instead of a reset and marks the device awake, so the next expiry is a reset. A clrwdt_i strobe also marks the device awake.
- R5: timeout_o becomes 1 in the same cycle as any reset or wake pulse and stays 1 until rst_ni.
- R6: The watchdog is enabled when cfg_en_i is 1, or when cfg_en_i is 0 and sw_en_i is 1. While it is disabled, no pulse is produced and the count is held at zero.
- R7: rc_req_o is 1 exactly while the watchdog is enabled.
- R8: Each of clrwdt_i, sleep_i, ircf_chg_i and clk_fail_i restarts the count from zero and blocks an expiry in the cycle it is seen.
- R9: After an expiry, counting restarts from zero, so the next expiry needs another full period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rc_tick_i | input | 1 | One-cycle strobe per RC oscillator period |
| cfg_en_i | input | 1 | Configuration enable (forces the watchdog on) |
| sw_en_i | input | 1 | Software enable, used only when cfg_en_i is 0 |
| tap_sel_i | input | TAP_W | Postscaler tap n, period = base * 2^n |
| clrwdt_i | input | 1 | Clear-watchdog strobe |
| sleep_i | input | 1 | Sleep-entry strobe |
| ircf_chg_i | input | 1 | Internal frequency select changed |
| clk_fail_i | input | 1 | Clock failure detected |
| rc_req_o | output | 1 | Keep the RC oscillator running |
| wdt_rst_o | output | 1 | One-cycle timeout reset request |
| wdt_wake_o | output | 1 | One-cycle timeout wake request |
| timeout_o | output | 1 | Sticky timeout flag |

## Verification
On every cycle the assertions check that each pulse lasts one cycle, that reset and wake never overlap, that the timeout flag accompanies every pulse and never drops, and that no pulse follows a disabled cycle or any restart strobe. The exact tick count up to expiry for each tap, the restart by each of the four clear sources, the choice between reset and wake after sleep entry, and the way the two enables combine can only be shown by the bench's scenarios, which count ticks and pulses at the ports.

// File: rtl/rc_wdt_pkg.sv
package rc_wdt_pkg;

  typedef struct packed {
    logic clrwdt;
    logic sleep;
    logic ircf;
    logic fail;
  } wdt_clr_t;

  function automatic logic any_clear(wdt_clr_t c);
    return c.clrwdt | c.sleep | c.ircf | c.fail;
  endfunction

endpackage

// File: rtl/rc_wdt_prescaler.sv
module rc_wdt_prescaler #(
  parameter int unsigned BASE_TICKS = 125,
  localparam int unsigned PRE_W = (BASE_TICKS > 1) ? $clog2(BASE_TICKS) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  output logic base_o
);

  logic [PRE_W-1:0] cnt_q;
  logic             wrap;

  assign wrap   = (cnt_q == PRE_W'(BASE_TICKS - 1));
  assign base_o = tick_i & wrap & ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i || base_o)   cnt_q <= '0;
    else if (tick_i)            cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/rc_wdt_postscaler.sv
module rc_wdt_postscaler #(
  parameter int unsigned POST_STAGES = 16,
  localparam int unsigned TAP_W = $clog2(POST_STAGES),
  localparam int unsigned CNT_W = POST_STAGES - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             base_i,
  input  logic             clr_i,
  input  logic [TAP_W-1:0] tap_sel_i,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] stage_hit;

  // stage i takes part in the compare only below the selected tap
  for (genvar i = 0; i < CNT_W; i++) begin : g_stage
    logic in_tap;
    assign in_tap       = ({1'b0, tap_sel_i} > (TAP_W + 1)'(i));
    assign stage_hit[i] = ~in_tap | cnt_q[i];
  end

  assign expire_o = base_i & (&stage_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i || expire_o)  cnt_q <= '0;
    else if (base_i)             cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/rc_watchdog.sv
module rc_watchdog #(
  parameter int unsigned BASE_TICKS  = 125,
  parameter int unsigned POST_STAGES = 16,
  localparam int unsigned TAP_W = $clog2(POST_STAGES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rc_tick_i,
  input  logic             cfg_en_i,
  input  logic             sw_en_i,
  input  logic [TAP_W-1:0] tap_sel_i,
  input  logic             clrwdt_i,
  input  logic             sleep_i,
  input  logic             ircf_chg_i,
  input  logic             clk_fail_i,
  output logic             rc_req_o,
  output logic             wdt_rst_o,
  output logic             wdt_wake_o,
  output logic             timeout_o
);
  import rc_wdt_pkg::*;

  wdt_clr_t clr_src;
  logic     wdt_en;
  logic     clr;
  logic     base_tick;
  logic     expire;
  logic     asleep_q;
  logic     rst_q, wake_q, tout_q;

  // software enable only matters with the config bit off
  assign wdt_en  = cfg_en_i ? 1'b1 : sw_en_i;
  assign clr_src = '{clrwdt: clrwdt_i, sleep: sleep_i, ircf: ircf_chg_i, fail: clk_fail_i};
  assign clr     = any_clear(clr_src) | ~wdt_en;

  rc_wdt_prescaler #(.BASE_TICKS(BASE_TICKS)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (rc_tick_i),
    .clr_i  (clr),
    .base_o (base_tick)
  );

  rc_wdt_postscaler #(.POST_STAGES(POST_STAGES)) u_post (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .base_i    (base_tick),
    .clr_i     (clr),
    .tap_sel_i (tap_sel_i),
    .expire_o  (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      asleep_q <= 1'b0;
      rst_q    <= 1'b0;
      wake_q   <= 1'b0;
      tout_q   <= 1'b0;
    end else begin
      rst_q  <= expire & ~asleep_q;
      wake_q <= expire & asleep_q;
      tout_q <= tout_q | expire;
      if (sleep_i)                              asleep_q <= 1'b1;
      else if (clrwdt_i || (expire && asleep_q)) asleep_q <= 1'b0;
    end
  end

  assign rc_req_o   = wdt_en;
  assign wdt_rst_o  = rst_q;
  assign wdt_wake_o = wake_q;
  assign timeout_o  = tout_q;

endmodule

// File: rtl/rc_watchdog_chk.sv
module rc_watchdog_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic clrwdt_i,
  input logic sleep_i,
  input logic ircf_chg_i,
  input logic clk_fail_i,
  input logic rc_req_o,
  input logic wdt_rst_o,
  input logic wdt_wake_o,
  input logic timeout_o
);

  AST_RST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |=> !wdt_rst_o); // R3

  AST_WAKE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_wake_o |=> !wdt_wake_o); // R4

  AST_PULSE_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wdt_rst_o && wdt_wake_o)); // R3

  AST_TIMEOUT_WITH_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_rst_o || wdt_wake_o) |-> timeout_o); // R5

  AST_TIMEOUT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> timeout_o); // R5

  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rc_req_o |=> (!wdt_rst_o && !wdt_wake_o)); // R6

  AST_CLEAR_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clrwdt_i || sleep_i || ircf_chg_i || clk_fail_i) |=> (!wdt_rst_o && !wdt_wake_o)); // R8

endmodule

bind rc_watchdog rc_watchdog_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clrwdt_i   (clrwdt_i),
  .sleep_i    (sleep_i),
  .ircf_chg_i (ircf_chg_i),
  .clk_fail_i (clk_fail_i),
  .rc_req_o   (rc_req_o),
  .wdt_rst_o  (wdt_rst_o),
  .wdt_wake_o (wdt_wake_o),
  .timeout_o  (timeout_o)
);

// File: tb/rc_watchdog_tb_top.sv
module rc_watchdog_tb_top;

  localparam int unsigned BASE = 2;
  localparam int NV = 5;
  localparam logic [3:0] VEC_SEL   [NV] = '{4'd0, 4'd1, 4'd3, 4'd5, 4'd12};
  localparam int         VEC_TICKS [NV] = '{2, 4, 16, 64, 8192};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rc_tick = 1'b0, cfg_en = 1'b1, sw_en = 1'b0;
  logic [3:0] tap_sel = 4'd0;
  logic clrwdt = 1'b0, sleep_s = 1'b0, ircf_chg = 1'b0, clk_fail = 1'b0;
  logic rc_req, wdt_rst, wdt_wake, timeout;

  int checks = 0, errors = 0;
  int rst_cnt = 0, wake_cnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rc_watchdog #(.BASE_TICKS(BASE), .POST_STAGES(16)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rc_tick_i(rc_tick), .cfg_en_i(cfg_en),
    .sw_en_i(sw_en), .tap_sel_i(tap_sel), .clrwdt_i(clrwdt), .sleep_i(sleep_s),
    .ircf_chg_i(ircf_chg), .clk_fail_i(clk_fail), .rc_req_o(rc_req),
    .wdt_rst_o(wdt_rst), .wdt_wake_o(wdt_wake), .timeout_o(timeout)
  );

  always @(posedge clk) begin
    if (wdt_rst)  rst_cnt  <= rst_cnt + 1;
    if (wdt_wake) wake_cnt <= wake_cnt + 1;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) rc_tick = 1'b1;
      @(negedge clk) rc_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic strobe(int which);
    @(negedge clk);
    case (which)
      0: clrwdt = 1'b1;
      1: sleep_s = 1'b1;
      2: ircf_chg = 1'b1;
      default: clk_fail = 1'b1;
    endcase
    @(negedge clk);
    clrwdt = 1'b0; sleep_s = 1'b0; ircf_chg = 1'b0; clk_fail = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int r0, w0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 rst", int'(wdt_rst), 0);
    chk("R1 wake", int'(wdt_wake), 0);
    chk("R1 timeout", int'(timeout), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R9: period per tap
    for (int v = 0; v < NV; v++) begin
      tap_sel = VEC_SEL[v];
      strobe(0);
      r0 = rst_cnt; w0 = wake_cnt;
      ticks(VEC_TICKS[v] - 1);
      chk("R2 early", rst_cnt - r0, 0);
      ticks(1);
      chk("R3 reset pulse", rst_cnt - r0, 1);
      chk("R3 no wake", wake_cnt - w0, 0);
    end
    // R9: second period back to back
    tap_sel = 4'd2;
    strobe(0);
    r0 = rst_cnt;
    ticks(8);
    chk("R9 first", rst_cnt - r0, 1);
    ticks(7);
    chk("R9 restart early", rst_cnt - r0, 1);
    ticks(1);
    chk("R9 second", rst_cnt - r0, 2);
    // R5: sticky
    chk("R5 timeout set", int'(timeout), 1);

    // R8: each clear source restarts
    for (int s = 0; s < 4; s++) begin
      strobe(0);
      r0 = rst_cnt; w0 = wake_cnt;
      ticks(7);
      strobe(s);
      if (s == 1) strobe(0); // leave sleep so expiry is a reset
      ticks(7);
      chk("R8 restarted", rst_cnt - r0 + wake_cnt - w0, 0);
      ticks(1);
      chk("R8 expiry after restart", rst_cnt - r0, 1);
    end

    // R4: sleep gives wake, then reset
    strobe(0);
    r0 = rst_cnt; w0 = wake_cnt;
    strobe(1);
    ticks(8);
    chk("R4 wake pulse", wake_cnt - w0, 1);
    chk("R4 no reset", rst_cnt - r0, 0);
    ticks(8);
    chk("R4 awake again", rst_cnt - r0, 1);
    chk("R4 single wake", wake_cnt - w0, 1);

    // R6 R7: enables
    @(negedge clk) begin cfg_en = 1'b0; sw_en = 1'b0; end
    @(negedge clk);
    chk("R7 req off", int'(rc_req), 0);
    r0 = rst_cnt;
    ticks(20);
    chk("R6 disabled", rst_cnt - r0, 0);
    @(negedge clk) sw_en = 1'b1;
    @(negedge clk);
    chk("R7 req sw", int'(rc_req), 1);
    ticks(8);
    chk("R6 sw enable", rst_cnt - r0, 1);
    @(negedge clk) begin cfg_en = 1'b1; sw_en = 1'b0; end
    @(negedge clk);
    chk("R7 req cfg", int'(rc_req), 1);
    ticks(8);
    chk("R6 cfg enable", rst_cnt - r0, 2);

    // R5: cleared only by reset
    chk("R5 still set", int'(timeout), 1);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    chk("R5 cleared by rst", int'(timeout), 0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule